// File: doc/BRIEF.md
# Round-Robin Block Lane Distributor

This block spreads a stream of typed 64-bit blocks over a bundle of parallel physical lanes. Each input block (64 data bits plus a 4-bit type code) is accepted through a valid/ready handshake. It is placed, unchanged, on exactly one lane output. Lanes are served in strict rotation starting at lane 0. The number of active lanes is chosen at run time from 1 up to `MAX_LANES` (default 10). Four lanes form a 40G bundle and ten lanes form a 100G bundle.

At a fixed interval the block pauses the input for one cycle and drives an alignment block on every active lane in the same slot. A receiver can then line up the lanes and remove the lane-to-lane skew. The lane count is sampled only in that alignment cycle, so a bundle never changes width in the middle of an alignment period. After reset the first thing the block emits is an alignment round.

Top module: `block_lane_distributor`

## Requirements
- R1: While reset is high and in the first cycle after reset is released, `in_ready` is low and no `lane_valid` bit is set. The first output round after reset is an alignment round.
- R2: A block accepted in a cycle (`in_valid` and `in_ready` both high) appears in the next cycle on exactly one lane, with `lane_valid` high for that lane. Its 64-bit data and 4-bit type are unchanged, including a type equal to the alignment code.
- R3: Accepted blocks go to lanes 0, 1, ..., N-1 in order and then wrap to lane 0. N is the active lane count. Lane i uses bits [64*i+63:64*i] of `lane_data` and bits [4*i+3:4*i] of `lane_type`.
- R4: The requested count `cfg_lanes` is clamped. A value of 0 acts as 1, and a value above `MAX_LANES` acts as `MAX_LANES`. Lanes at or above the active count never assert `lane_valid`.
- R5: An alignment round lasts one cycle with `in_ready` low, and any block offered in that cycle is not taken. In the next cycle every active lane shows `lane_valid` high, type 4'b1011 and data 64'hA5A5_A5A5_A5A5_A5A5, and every inactive lane is idle.
- R6: After an alignment round, the next alignment round starts right after `ALIGN_PERIOD` (default 4) complete data rounds, which is `ALIGN_PERIOD`*N accepted blocks.
- R7: A change of `cfg_lanes` takes effect only in the next alignment round. From that point on, distribution restarts at lane 0 with the new count.
- R8: A cycle with `in_valid` low outside alignment produces no `lane_valid` in the next cycle. It does not advance the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lanes | input | 4 | Requested number of active lanes |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Block can be accepted this cycle |
| in_data | input | 64 | Input block payload |
| in_type | input | 4 | Input block type code |
| lane_valid | output | 10 | Per-lane strobe, bit i for lane i |
| lane_data | output | 640 | Per-lane 64-bit blocks, lane i at bits [64*i+63:64*i] |
| lane_type | output | 40 | Per-lane 4-bit type codes, lane i at bits [4*i+3:4*i] |

## Verification
The bench first sends back-to-back blocks on four lanes. This shows the rotation order and shows that the alignment interval is counted in rounds, not in blocks. It then inserts idle cycles partway through a round, which tells a pointer that holds apart from one that skips lanes. It changes the lane count in the middle of a period, so that a count applied early can be told apart from one deferred to the alignment round. It also drives counts of 0 and 15 to exercise the clamp at both ends. Payload types run through all sixteen codes, including the alignment code, to show that the type field passes through untouched.

// File: rtl/blkdist_pkg.sv
package blkdist_pkg;

    localparam int BLK_W  = 64;
    localparam int TYPE_W = 4;
    localparam int CHAR_W = 8;

    localparam logic [TYPE_W-1:0] TYPE_ALIGN = 4'b1011;
    localparam logic [CHAR_W-1:0] ALIGN_CHAR = 8'hA5;

    typedef logic [BLK_W-1:0]  blk_data_t;
    typedef logic [TYPE_W-1:0] blk_type_t;

    typedef struct packed {
        blk_type_t btype;
        blk_data_t data;
    } blk_t;

    typedef enum logic {
        PH_ALIGN = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    // Alignment block: alignment type plus identical filler characters.
    function automatic blk_t make_align_blk();
        blk_t r;
        r.btype = TYPE_ALIGN;
        r.data  = {(BLK_W / CHAR_W){ALIGN_CHAR}};
        return r;
    endfunction

endpackage

// File: rtl/blkdist_ctrl.sv
module blkdist_ctrl
    import blkdist_pkg::*;
#(
    parameter int MAX_LANES    = 10,
    parameter int ALIGN_PERIOD = 4,
    parameter int CNT_W        = 4,
    parameter int PTR_W        = 4,
    parameter int RND_W        = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CNT_W-1:0]     cfg_lanes,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 align_now,
    output logic [MAX_LANES-1:0] lane_en,
    output logic [MAX_LANES-1:0] data_sel
);

    phase_e           phase;
    logic [CNT_W-1:0] act_n;
    logic [CNT_W-1:0] req_n;
    logic [CNT_W-1:0] lanes_now;
    logic [PTR_W-1:0] ptr;
    logic [RND_W-1:0] rnd;
    logic             fire;
    logic             last_lane;
    logic             last_rnd;

    // Clamp the requested lane count into 1..MAX_LANES.
    always_comb begin
        if (cfg_lanes == '0)
            req_n = CNT_W'(1);
        else if (cfg_lanes > CNT_W'(MAX_LANES))
            req_n = CNT_W'(MAX_LANES);
        else
            req_n = cfg_lanes;
    end

    assign in_ready  = (phase == PH_DATA);
    assign align_now = (phase == PH_ALIGN);
    assign fire      = in_valid && in_ready;
    assign lanes_now = align_now ? req_n : act_n;
    assign last_lane = (CNT_W'(ptr) + CNT_W'(1)) == act_n;
    assign last_rnd  = (rnd == RND_W'(ALIGN_PERIOD - 1));

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_sel
        assign lane_en[g]  = (lanes_now > CNT_W'(g));
        assign data_sel[g] = fire && (ptr == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_ALIGN;
            act_n <= CNT_W'(1);
            ptr   <= '0;
            rnd   <= '0;
        end else if (phase == PH_ALIGN) begin
            act_n <= req_n;
            ptr   <= '0;
            rnd   <= '0;
            phase <= PH_DATA;
        end else if (fire) begin
            if (last_lane) begin
                ptr <= '0;
                if (last_rnd) begin
                    rnd   <= '0;
                    phase <= PH_ALIGN;
                end else begin
                    rnd <= rnd + RND_W'(1);
                end
            end else begin
                ptr <= ptr + PTR_W'(1);
            end
        end
    end

    // R3: the pointer stays inside the active bundle
    p_ptr_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> (CNT_W'(ptr) < act_n));

    // R4: the latched count stays within 1..MAX_LANES
    p_count_range_r4: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> ((act_n != '0) && (act_n <= CNT_W'(MAX_LANES))));

    // R6: the period ends after the last lane of the last round
    p_align_after_period_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && last_lane && last_rnd) |=> !in_ready);

    // R5: an alignment round takes a single cycle
    p_align_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

    // R8: an idle data cycle leaves the rotation alone
    p_stall_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> ($stable(ptr) && $stable(rnd)));

endmodule

// File: rtl/blkdist_lane.sv
module blkdist_lane
    import blkdist_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_align,
    input  logic load_data,
    input  blk_t in_blk,
    output logic out_valid,
    output blk_t out_blk
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_blk   <= '0;
        end else begin
            out_valid <= load_align || load_data;
            if (load_align)
                out_blk <= make_align_blk();
            else if (load_data)
                out_blk <= in_blk;
        end
    end

    // R5: no data block can collide with an alignment slot
    p_lane_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
        !(load_align && load_data));

endmodule

// File: rtl/block_lane_distributor.sv
module block_lane_distributor
    import blkdist_pkg::*;
#(
    parameter int MAX_LANES    = 10,
    parameter int ALIGN_PERIOD = 4,
    localparam int CNT_W = $clog2(MAX_LANES + 1),
    localparam int PTR_W = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
    localparam int RND_W = (ALIGN_PERIOD > 1) ? $clog2(ALIGN_PERIOD) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CNT_W-1:0]            cfg_lanes,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [BLK_W-1:0]            in_data,
    input  logic [TYPE_W-1:0]           in_type,
    output logic [MAX_LANES-1:0]        lane_valid,
    output logic [MAX_LANES*BLK_W-1:0]  lane_data,
    output logic [MAX_LANES*TYPE_W-1:0] lane_type
);

    logic                 align_now;
    logic [MAX_LANES-1:0] lane_en;
    logic [MAX_LANES-1:0] data_sel;
    blk_t                 in_blk;

    assign in_blk.data  = in_data;
    assign in_blk.btype = in_type;

    blkdist_ctrl #(
        .MAX_LANES    (MAX_LANES),
        .ALIGN_PERIOD (ALIGN_PERIOD),
        .CNT_W        (CNT_W),
        .PTR_W        (PTR_W),
        .RND_W        (RND_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_lanes (cfg_lanes),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .align_now (align_now),
        .lane_en   (lane_en),
        .data_sel  (data_sel)
    );

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        blk_t lane_blk;

        blkdist_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .load_align (align_now && lane_en[g]),
            .load_data  (data_sel[g]),
            .in_blk     (in_blk),
            .out_valid  (lane_valid[g]),
            .out_blk    (lane_blk)
        );

        assign lane_data[g*BLK_W +: BLK_W]   = lane_blk.data;
        assign lane_type[g*TYPE_W +: TYPE_W] = lane_blk.btype;
    end

    // R2: an accepted block lands on exactly one lane
    p_one_lane_per_block_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ($countones(lane_valid) == 1));

    // R5: an alignment cycle is followed by alignment output
    p_align_fills_lanes_r5: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> (lane_valid[0] && (lane_type[TYPE_W-1:0] == TYPE_ALIGN)));

    // R8: an idle data cycle produces no lane output
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (lane_valid == '0));

endmodule

// File: tb/block_lane_distributor_test.sv
`timescale 1ns/1ps
module block_lane_distributor_test;

    localparam logic [3:0]  ALIGN_TYPE = 4'b1011;
    localparam logic [63:0] ALIGN_DATA = 64'hA5A5_A5A5_A5A5_A5A5;
    localparam int NL     = 10;
    localparam int PERIOD = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    cfg_lanes = 4'd4;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [63:0]   in_data = '0;
    logic [3:0]    in_type = '0;
    logic [NL-1:0] lane_valid;
    logic [NL*64-1:0] lane_data;
    logic [NL*4-1:0]  lane_type;

    int n_chk = 0;
    int n_bad = 0;
    int exp_n = 1;
    int exp_ptr = 0;
    int exp_rnd = 0;
    int seq = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    block_lane_distributor uut (
        .clk        (clk),
        .rst        (rst),
        .cfg_lanes  (cfg_lanes),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_type    (in_type),
        .lane_valid (lane_valid),
        .lane_data  (lane_data),
        .lane_type  (lane_type)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int clampn(input int c);
        if (c == 0) return 1;
        if (c > NL) return NL;
        return c;
    endfunction

    // R5: one stalled cycle, then alignment on all active lanes
    task automatic expect_align(input string req);
        int n;
        logic [NL-1:0] mask;
        n = clampn(int'(cfg_lanes));
        mask = NL'((1 << n) - 1);
        check(in_ready == 1'b0, req, "ready low in align slot", 64'(in_ready), 64'd0);
        in_valid = 1'b1;
        in_data  = 64'hBAD0_BAD0_BAD0_BAD0;
        in_type  = 4'h0;
        step();
        in_valid = 1'b0;
        check(lane_valid == mask, req, "align lane mask", 64'(lane_valid), 64'(mask));
        for (int i = 0; i < n; i++) begin
            check(lane_type[i*4 +: 4] == ALIGN_TYPE, req, "align type",
                  64'(lane_type[i*4 +: 4]), 64'(ALIGN_TYPE));
            check(lane_data[i*64 +: 64] == ALIGN_DATA, req, "align data",
                  lane_data[i*64 +: 64], ALIGN_DATA);
        end
        check(in_ready == 1'b1, "R5", "ready back after align", 64'(in_ready), 64'd1);
        exp_n = n;
        exp_ptr = 0;
        exp_rnd = 0;
    endtask

    // R2 / R3: send one block, check its lane; handles period end (R6)
    task automatic send(input string req);
        logic [63:0] d;
        logic [3:0]  t;
        d = {32'h5EED_0000 + 32'(seq), 32'(seq * 7 + 3)};
        t = 4'(seq);
        check(in_ready == 1'b1, req, "ready in data phase", 64'(in_ready), 64'd1);
        in_valid = 1'b1;
        in_data  = d;
        in_type  = t;
        step();
        in_valid = 1'b0;
        check(lane_valid == (NL'(1) << exp_ptr), req, "lane select",
              64'(lane_valid), 64'(NL'(1) << exp_ptr));
        check(lane_data[exp_ptr*64 +: 64] == d, "R2", "lane data",
              lane_data[exp_ptr*64 +: 64], d);
        check(lane_type[exp_ptr*4 +: 4] == t, "R2", "lane type",
              64'(lane_type[exp_ptr*4 +: 4]), 64'(t));
        seq++;
        exp_ptr++;
        if (exp_ptr == exp_n) begin
            exp_ptr = 0;
            exp_rnd++;
            if (exp_rnd == PERIOD) expect_align("R6");
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cfg_lanes = 4'd4;
        repeat (3) step();
        check(in_ready == 1'b0, "R1", "ready during reset", 64'(in_ready), 64'd0);
        check(lane_valid == '0, "R1", "lanes during reset", 64'(lane_valid), 64'd0);
        rst = 1'b0;
        check(in_ready == 1'b0, "R1", "ready after release", 64'(in_ready), 64'd0);
        check(lane_valid == '0, "R1", "lanes after release", 64'(lane_valid), 64'd0);
        expect_align("R1");
    endtask

    task automatic t_rotation();
        for (int k = 0; k < 4 * PERIOD; k++) send("R3");
    endtask

    task automatic t_stall();
        send("R3");
        send("R3");
        for (int k = 0; k < 3; k++) begin
            step();
            check(lane_valid == '0, "R8", "idle cycle output", 64'(lane_valid), 64'd0);
            check(in_ready == 1'b1, "R8", "ready while idle", 64'(in_ready), 64'd1);
        end
        for (int k = 0; k < 4 * PERIOD - 2; k++) send("R8");
    endtask

    task automatic t_count_change();
        for (int k = 0; k < 5; k++) send("R7");
        cfg_lanes = 4'd10;
        for (int k = 0; k < 4 * PERIOD - 5; k++) send("R7");
        check(exp_n == 10, "R7", "count applied at align", 64'(exp_n), 64'd10);
        for (int k = 0; k < 20; k++) send("R3");
        cfg_lanes = 4'd0;
        for (int k = 0; k < 10 * PERIOD - 20; k++) send("R7");
    endtask

    task automatic t_clamp();
        check(exp_n == 1, "R4", "zero count acts as one", 64'(exp_n), 64'd1);
        cfg_lanes = 4'd15;
        for (int k = 0; k < PERIOD; k++) send("R4");
        check(exp_n == NL, "R4", "large count clamps", 64'(exp_n), 64'(NL));
        for (int k = 0; k < NL * PERIOD; k++) send("R4");
    endtask

    initial begin
        step();
        t_reset();
        t_rotation();
        t_stall();
        t_count_change();
        t_clamp();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule